// File: doc/BRIEF.md
# General-Purpose I/O Register Bank

This block puts a bank of general-purpose I/O lines behind a small single-cycle register port. Software writes an output latch and a direction latch through a handful of word addresses. The block drives one output value and one output enable per line, and it reads the pad levels back through a two-stage synchronizer. The number of lines equals the register width, which can be 8, 16, 32 or 64 bits.

The output latch can be written in three ways. A full-value data write replaces the whole latch. A set register forces selected lines high. A clear register forces selected lines low. When the clear register is left out at elaboration, the set register carries the full output value instead. Direction can also be written in two ways. One view marks outputs with 1 and the other marks inputs with 1. Both views act on the same direction state, so each always reads back as the complement of the other.

Two elaboration options change how register bits line up with lines. Bit mirroring reverses the line order. Byte swapping reverses the byte order on every access. Both options act the same way on reads and on writes.

Top module: `gpio_regbank`

## Requirements
- R1: After synchronous reset, every `pin_out` and `pin_oe` bit is 0 and the set register reads 0. The output-select direction register reads all zeros and the input-select direction register reads all ones.
- R2: A read of address 0 (data) returns the `pin_in` levels after a two-flop synchronizer. A pin change made before clock edge k appears in read data captured at edge k+2 and not earlier.
- R3: With the clear register present, a write to address 1 (set) drives high every line whose bit is 1. A line whose bit is 0 keeps its value.
- R4: With the clear register present, a write to address 2 (clear) drives low every line whose bit is 1 and leaves the other lines unchanged. Address 2 always reads 0.
- R5: When elaborated without the clear register, a write to address 1 loads the whole output latch, so 1 drives high and 0 drives low. Writes to address 2 then change nothing.
- R6: A write to address 0 loads the whole output latch with the written value.
- R7: With the readback option on, a read of address 1 returns the output latch. With the option off, it returns 0.
- R8: A write to address 3 (output-select) sets the direction so that a 1 bit makes that line an output (`pin_oe` = 1) and a 0 bit makes it an input. The register reads back the direction state.
- R9: A write to address 4 (input-select) sets the direction so that a 1 bit makes that line an input. Address 4 always reads the bitwise complement of address 3.
- R10: With mirroring on, line n corresponds to register bit WIDTH-1-n in every register, for both reads and writes.
- R11: With byte swapping on, register byte k corresponds to line byte NB-1-k for widths 16 and 32. The option has no effect at width 8 and is rejected at elaboration for width 64. Only widths 8, 16, 32 and 64 are accepted.
- R12: Read data appears in the cycle after the read strobe and is 0 in any cycle that follows no read. Addresses 5 to 7 read 0 and ignore writes. A write changes `pin_out`/`pin_oe` at the next clock edge. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word address |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | WIDTH | Read data, registered |
| pin_in | input | WIDTH | Line levels from the pads |
| pin_out | output | WIDTH | Driven line values |
| pin_oe | output | WIDTH | Per-line output enable |

## Verification
A read strobe and a write strobe can both be asserted in the same cycle on the same register. This block must then return the value the latch held before the write, and the new value must appear on the pins at that same edge. The bench raises both strobes on the set register together. It then checks three things: the captured read data equals the old latch, `pin_out` already shows the new bit, and a follow-up read returns the updated value. A second configuration repeats the mapping checks with mirroring, byte swapping and no clear register. Its expected values come from a separate bit-permutation function in the bench.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA    = 3'd0,
        REG_SET     = 3'd1,
        REG_CLR     = 3'd2,
        REG_DIR_OUT = 3'd3,
        REG_DIR_IN  = 3'd4
    } gpio_reg_e;

    typedef struct packed {
        logic      wr;
        gpio_reg_e sel;
    } gpio_wcmd_t;

    function automatic bit width_ok(int w);
        return (w == 8) || (w == 16) || (w == 32) || (w == 64);
    endfunction

    function automatic bit addr_mapped(logic [ADDR_W-1:0] a);
        return a <= 3'd4;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/gpio_lane_map.sv
module gpio_lane_map #(
    parameter int WIDTH     = 32,
    parameter bit MIRROR    = 1'b0,
    parameter bit BYTE_SWAP = 1'b0
) (
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] dst
);
    localparam int NB      = WIDTH / 8;
    localparam bit DO_SWAP = BYTE_SWAP && (WIDTH > 8) && (WIDTH < 64);

    logic [WIDTH-1:0] swapped;

    // The swap and the mirror each undo themselves and commute,
    // so one mapper serves both the write and the read direction.
    generate
        if (DO_SWAP) begin : g_swap
            for (genvar b = 0; b < NB; b++) begin : g_byte
                assign swapped[8*b +: 8] = src[8*(NB-1-b) +: 8];
            end
        end else begin : g_noswap
            assign swapped = src;
        end

        if (MIRROR) begin : g_mirror
            for (genvar n = 0; n < WIDTH; n++) begin : g_bit
                assign dst[n] = swapped[WIDTH-1-n];
            end
        end else begin : g_straight
            assign dst = swapped;
        end
    endgenerate
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
    import gpio_regbank_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter bit HAS_CLR = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  gpio_wcmd_t       cmd,
    input  logic [WIDTH-1:0] wv,
    output logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] dir_q
);
    logic [WIDTH-1:0] out_nx;
    logic [WIDTH-1:0] dir_nx;

    always_comb begin
        out_nx = out_q;
        dir_nx = dir_q;
        if (cmd.wr) begin
            case (cmd.sel)
                REG_DATA:    out_nx = wv;
                REG_SET:     out_nx = HAS_CLR ? (out_q | wv) : wv;
                REG_CLR:     out_nx = HAS_CLR ? (out_q & ~wv) : out_q;
                REG_DIR_OUT: dir_nx = wv;
                REG_DIR_IN:  dir_nx = ~wv;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            dir_q <= '0;
        end else begin
            out_q <= out_nx;
            dir_q <= dir_nx;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (out_q == '0) && (dir_q == '0));

    assert_dir_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(cmd.wr && (cmd.sel == REG_DIR_OUT || cmd.sel == REG_DIR_IN))
        |=> $stable(dir_q));

    assert_data_load_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.sel == REG_DATA) |=> (out_q == $past(wv)));

    generate
        if (HAS_CLR) begin : g_clr_checks
            assert_set_high_R3: assert property (@(posedge clk) disable iff (rst)
                (cmd.wr && cmd.sel == REG_SET)
                |=> ((out_q & $past(wv)) == $past(wv)));

            assert_clr_low_R4: assert property (@(posedge clk) disable iff (rst)
                (cmd.wr && cmd.sel == REG_CLR)
                |=> ((out_q & $past(wv)) == '0));
        end else begin : g_noclr_checks
            assert_clr_ignored_R5: assert property (@(posedge clk) disable iff (rst)
                (cmd.wr && cmd.sel == REG_CLR) |=> $stable(out_q));
        end
    endgenerate
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_regbank_pkg::*;
#(
    parameter int WIDTH        = 32,
    parameter bit MIRROR       = 1'b0,
    parameter bit BYTE_SWAP    = 1'b0,
    parameter bit HAS_CLR      = 1'b1,
    parameter bit SET_READBACK = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic              bus_ren,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe
);
    generate
        if (!width_ok(WIDTH)) begin : g_bad_width
            $error("gpio_regbank: WIDTH must be 8, 16, 32 or 64");
        end
        if (BYTE_SWAP && WIDTH == 64) begin : g_bad_swap
            $error("gpio_regbank: byte swapping is not allowed at width 64");
        end
    endgenerate

    gpio_wcmd_t       wcmd;
    logic [WIDTH-1:0] wr_line;
    logic [WIDTH-1:0] out_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] rd_line;
    logic [WIDTH-1:0] rd_bus;

    assign wcmd.wr  = bus_wen && addr_mapped(bus_addr);
    assign wcmd.sel = gpio_reg_e'(bus_addr);

    gpio_lane_map #(.WIDTH(WIDTH), .MIRROR(MIRROR), .BYTE_SWAP(BYTE_SWAP)) u_wmap (
        .src (bus_wdata),
        .dst (wr_line)
    );

    gpio_out_latch #(.WIDTH(WIDTH), .HAS_CLR(HAS_CLR)) u_latch (
        .clk   (clk),
        .rst   (rst),
        .cmd   (wcmd),
        .wv    (wr_line),
        .out_q (out_q),
        .dir_q (dir_q)
    );

    gpio_sync #(.WIDTH(WIDTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    always_comb begin
        case (bus_addr)
            REG_DATA:    rd_line = pin_sync;
            REG_SET:     rd_line = SET_READBACK ? out_q : '0;
            REG_DIR_OUT: rd_line = dir_q;
            REG_DIR_IN:  rd_line = ~dir_q;
            default:     rd_line = '0;
        endcase
    end

    gpio_lane_map #(.WIDTH(WIDTH), .MIRROR(MIRROR), .BYTE_SWAP(BYTE_SWAP)) u_rmap (
        .src (rd_line),
        .dst (rd_bus)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_ren) begin
            bus_rdata <= rd_bus;
        end else begin
            bus_rdata <= '0;
        end
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;

    assert_rdata_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !bus_ren |=> (bus_rdata == '0));

    assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (rst)
        (bus_ren && !addr_mapped(bus_addr)) |=> (bus_rdata == '0));

    assert_clr_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_ren && bus_addr == REG_CLR) |=> (bus_rdata == '0));

    assert_unmapped_write_R12: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && !addr_mapped(bus_addr)) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

// File: tb/gpio_regbank_test.sv
`timescale 1ns/1ps
module gpio_regbank_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    // Main instance: 32 lines, straight mapping, clear register, readback on.
    logic [2:0]  addr  = '0;
    logic        wen   = 1'b0;
    logic        ren   = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    gpio_regbank #(.WIDTH(32)) uut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wen(wen), .bus_wdata(wdata),
        .bus_ren(ren), .bus_rdata(rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Second instance: 16 lines, mirrored, byte swapped, no clear, no readback.
    logic [2:0]  a_addr  = '0;
    logic        a_wen   = 1'b0;
    logic        a_ren   = 1'b0;
    logic [15:0] a_wdata = '0;
    logic [15:0] a_rdata;
    logic [15:0] a_pin_in = '0;
    logic [15:0] a_pin_out;
    logic [15:0] a_pin_oe;

    gpio_regbank #(.WIDTH(16), .MIRROR(1'b1), .BYTE_SWAP(1'b1),
                   .HAS_CLR(1'b0), .SET_READBACK(1'b0)) uut_alt (
        .clk(clk), .rst(rst), .bus_addr(a_addr), .bus_wen(a_wen), .bus_wdata(a_wdata),
        .bus_ren(a_ren), .bus_rdata(a_rdata), .pin_in(a_pin_in),
        .pin_out(a_pin_out), .pin_oe(a_pin_oe)
    );

    // Register word -> line vector for the second instance: byte swap, then mirror.
    function automatic logic [15:0] map16(logic [15:0] x);
        logic [15:0] s;
        logic [15:0] y;
        s = {x[7:0], x[15:8]};
        for (int n = 0; n < 16; n++) y[n] = s[15-n];
        return y;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // All tasks start and end on a falling edge.
    task automatic wr(logic [2:0] a, logic [31:0] d);
        addr = a; wdata = d; wen = 1'b1;
        @(negedge clk);
        wen = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] v);
        addr = a; ren = 1'b1;
        @(negedge clk);
        ren = 1'b0;
        v = rdata;
    endtask

    task automatic a_wr(logic [2:0] a, logic [15:0] d);
        a_addr = a; a_wdata = d; a_wen = 1'b1;
        @(negedge clk);
        a_wen = 1'b0;
    endtask

    task automatic a_rd(logic [2:0] a, output logic [15:0] v);
        a_addr = a; a_ren = 1'b1;
        @(negedge clk);
        a_ren = 1'b0;
        v = a_rdata;
    endtask

    // {addr[3], wdata[32], expected pin_out[32], expected pin_oe[32]}
    localparam int NVEC = 9;
    localparam logic [98:0] VEC [NVEC] = '{
        {3'd0, 32'h0000_00FF, 32'h0000_00FF, 32'h0000_0000},  // R6 full load
        {3'd1, 32'h0000_FF00, 32'h0000_FFFF, 32'h0000_0000},  // R3 set ones
        {3'd2, 32'h0000_000F, 32'h0000_FFF0, 32'h0000_0000},  // R4 clear ones
        {3'd1, 32'h0000_0000, 32'h0000_FFF0, 32'h0000_0000},  // R3 zero set no-op
        {3'd2, 32'h0000_0000, 32'h0000_FFF0, 32'h0000_0000},  // R4 zero clear no-op
        {3'd3, 32'hA5A5_0000, 32'h0000_FFF0, 32'hA5A5_0000},  // R8 output-select
        {3'd4, 32'hFFFF_0F0F, 32'h0000_FFF0, 32'h0000_F0F0},  // R9 input-select
        {3'd0, 32'h1234_5678, 32'h1234_5678, 32'h0000_F0F0},  // R6 full reload
        {3'd6, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0000_F0F0}   // R12 unmapped write
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        logic [15:0] av;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 pin_out", 64'(pin_out), 64'h0);
        check("R1 pin_oe", 64'(pin_oe), 64'h0);
        rd(3'd3, v); check("R1 dir_out read", 64'(v), 64'h0);
        rd(3'd4, v); check("R1 dir_in read", 64'(v), 64'hFFFF_FFFF);
        rd(3'd1, v); check("R1 set read", 64'(v), 64'h0);

        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][98:96], VEC[i][95:64]);
            check($sformatf("vec%0d pin_out", i), 64'(pin_out), 64'(VEC[i][63:32]));
            check($sformatf("vec%0d pin_oe", i), 64'(pin_oe), 64'(VEC[i][31:0]));
        end

        rd(3'd4, v); check("R9 dir_in complement", 64'(v), 64'hFFFF_0F0F);
        rd(3'd3, v); check("R8 dir_out readback", 64'(v), 64'h0000_F0F0);
        rd(3'd1, v); check("R7 set readback", 64'(v), 64'h1234_5678);
        rd(3'd2, v); check("R4 clear reads zero", 64'(v), 64'h0);
        rd(3'd5, v); check("R12 unmapped read", 64'(v), 64'h0);
        @(negedge clk);
        check("R12 idle rdata zero", 64'(rdata), 64'h0);

        // R12: read and write of the set register in one cycle
        addr = 3'd1; wdata = 32'h8000_0000; wen = 1'b1; ren = 1'b1;
        @(negedge clk);
        wen = 1'b0; ren = 1'b0;
        check("R12 same-cycle read old", 64'(rdata), 64'h1234_5678);
        check("R12 same-cycle pin_out new", 64'(pin_out), 64'h9234_5678);
        rd(3'd1, v); check("R7 readback after write", 64'(v), 64'h9234_5678);

        // R2: two-flop synchronizer latency on data reads
        pin_in = 32'hDEAD_BEEF;
        rd(3'd0, v); check("R2 first read old", 64'(v), 64'h0);
        rd(3'd0, v); check("R2 second read old", 64'(v), 64'h0);
        rd(3'd0, v); check("R2 third read new", 64'(v), 64'hDEAD_BEEF);

        // R5, R10, R11: mirrored, swapped, no-clear instance
        check("R1 alt reset oe", 64'(a_pin_oe), 64'h0);
        a_wr(3'd1, 16'h0001); check("R10 R11 alt set map", 64'(a_pin_out), 64'(map16(16'h0001)));
        a_wr(3'd1, 16'h8000); check("R5 alt set full value", 64'(a_pin_out), 64'(map16(16'h8000)));
        a_wr(3'd2, 16'hFFFF); check("R5 alt clear ignored", 64'(a_pin_out), 64'(map16(16'h8000)));
        a_wr(3'd3, 16'h00F0); check("R10 R11 alt oe map", 64'(a_pin_oe), 64'(map16(16'h00F0)));
        a_rd(3'd3, av); check("R10 alt dir readback", 64'(av), 64'h00F0);
        a_rd(3'd1, av); check("R7 alt no readback", 64'(av), 64'h0);
        a_pin_in = 16'h0001;
        repeat (3) @(negedge clk);
        a_rd(3'd0, av); check("R11 alt data read map", 64'(av), 64'h0080);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule